// File: doc/BRIEF.md
# Issue Window with Replay Timers

This block is an eight-slot instruction scheduler for an out-of-order core that speculates on load latency. Each slot holds the two source operand tags of a waiting instruction (tags are reorder-buffer ids), one ready flag per operand, a lifecycle state and a small countdown timer. Result tags arrive on a broadcast bus and set the matching ready flags. In each cycle the lowest-numbered slot whose operands are both ready is granted for issue.

Dependents of a load are woken before anyone knows whether the load hit. To cover that case, a slot's timer is reloaded whenever the slot is woken or granted, and it then counts down. While the timer is nonzero the slot is exposed. A single kill input, raised when a load overruns its expected latency, sends every exposed slot back to waiting with both operand flags clear. The slot keeps its place and its tags, and a later re-broadcast of the tags wakes it again. A granted slot whose timer runs out is past the point of squash and leaves the window.

Top module: `replay_iwin`

## Requirements
- R1: After reset every slot is free: alloc_ready is 1 and issue_valid is 0.
- R2: An accepted allocation writes the lowest-numbered free slot, with its operand ready flags taken from alloc_rdy0/alloc_rdy1. alloc_ready is 0 while all DEPTH slots are occupied, and an allocation attempted then has no effect.
- R3: When wb_valid is 1, a broadcast whose wb_tag equals a source tag of a waiting slot sets that operand's ready flag. The broadcast has no effect when wb_valid is 0, and none on a slot being allocated in the same cycle.
- R4: A slot is eligible when it is occupied, both of its flags are set and it is not issued. issue_valid and issue_idx (a binary slot number) show the lowest-numbered eligible slot in the same cycle. The granted slot is marked issued at the next clock edge.
- R5: A slot's timer is loaded with VUL_CYC (default 4) when the slot is granted, and also when a broadcast newly sets one of its flags. Otherwise it falls by one per cycle and stays at zero once it gets there.
- R6: An issued slot becomes free at the VUL_CYC-th clock edge after the edge that granted it, and can then be allocated again.
- R7: In a cycle with kill at 1, nothing issues. Every occupied slot whose timer is nonzero returns to waiting, with both flags clear and its timer at zero, and it ignores any broadcast in that cycle. A slot whose timer is zero is not affected by the kill.
- R8: A slot reverted by a kill issues again once both of its source tags have been broadcast again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Request to insert an instruction |
| alloc_tag0 | input | TAG_W | First source tag of the new instruction |
| alloc_tag1 | input | TAG_W | Second source tag of the new instruction |
| alloc_rdy0 | input | 1 | First operand is already available |
| alloc_rdy1 | input | 1 | Second operand is already available |
| alloc_ready | output | 1 | At least one slot is free |
| wb_valid | input | 1 | A result tag is on the broadcast bus |
| wb_tag | input | TAG_W | Broadcast result tag |
| kill | input | 1 | Load latency misspeculation, revert exposed slots |
| issue_valid | output | 1 | A slot is granted this cycle |
| issue_idx | output | IDX_W | Number of the granted slot |

## Verification
Selection is driven with a shared tag that wakes four alternating slots in one cycle, so the issue order has to come out as 0, 2, 4, 6. A fill-to-capacity run shows the full flag and a rejected insert. The kill input is swept over every delay from zero to beyond VUL_CYC after a grant, and the slot number taken by a following allocation shows whether the slot was reverted or had already retired. Further patterns separate the timer loaded at wakeup from the timer loaded at grant. They show that a timer which has counted down to zero sits there rather than wrapping around, since a slot woken long ago survives a kill while recently issued ones fall back. They also show that a gated or same-cycle broadcast changes nothing.

// File: rtl/replay_iwin_pkg.sv
package replay_iwin_pkg;

   // lifecycle of one window slot
   typedef enum logic [1:0] {
      SLOT_FREE   = 2'd0,
      SLOT_WAIT   = 2'd1,
      SLOT_ISSUED = 2'd2
   } slot_st_e;

   localparam int DEF_DEPTH   = 8;
   localparam int DEF_TAG_W   = 5;
   localparam int DEF_VUL_CYC = 4;

endpackage

// File: rtl/replay_iwin_pick.sv
// Lowest-index priority picker, used for both issue grant and free-slot search.
module replay_iwin_pick #(
   parameter  int W     = 8,
   localparam int IDX_W = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]     req,
   output logic             hit,
   output logic [IDX_W-1:0] idx,
   output logic [W-1:0]     onehot
);

   always_comb begin
      hit = 1'b0;
      idx = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (req[i]) begin
            hit = 1'b1;
            idx = IDX_W'(i);
         end
      end
      onehot = '0;
      if (hit) onehot[idx] = 1'b1;
   end

endmodule

// File: rtl/replay_iwin_slot.sv
// One window slot: operand tags, ready flags, state and vulnerability timer.
module replay_iwin_slot
   import replay_iwin_pkg::*;
#(
   parameter  int TAG_W   = DEF_TAG_W,
   parameter  int VUL_CYC = DEF_VUL_CYC,
   localparam int TMR_W   = $clog2(VUL_CYC + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld,
   input  logic [TAG_W-1:0] ld_tag0,
   input  logic [TAG_W-1:0] ld_tag1,
   input  logic             ld_rdy0,
   input  logic             ld_rdy1,
   input  logic             wb_valid,
   input  logic [TAG_W-1:0] wb_tag,
   input  logic             kill,
   input  logic             gnt,
   output logic             req,
   output logic             busy,
   output logic             issued,
   output logic [TMR_W-1:0] tmr
);

   slot_st_e         st_q;
   logic [TAG_W-1:0] tag0_q, tag1_q;
   logic [1:0]       rdy_q;
   logic [TMR_W-1:0] tmr_q;
   logic [1:0]       hit;
   logic             exposed;

   assign hit[0]  = wb_valid && (wb_tag == tag0_q);
   assign hit[1]  = wb_valid && (wb_tag == tag1_q);
   assign exposed = (tmr_q != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= SLOT_FREE;
         tag0_q <= '0;
         tag1_q <= '0;
         rdy_q  <= '0;
         tmr_q  <= '0;
      end else if (ld) begin
         st_q   <= SLOT_WAIT;
         tag0_q <= ld_tag0;
         tag1_q <= ld_tag1;
         rdy_q  <= {ld_rdy1, ld_rdy0};
         tmr_q  <= '0;
      end else if (st_q != SLOT_FREE) begin
         if (kill && exposed) begin
            st_q  <= SLOT_WAIT;
            rdy_q <= '0;
            tmr_q <= '0;
         end else if (st_q == SLOT_ISSUED) begin
            if (tmr_q <= TMR_W'(1)) begin
               st_q  <= SLOT_FREE;
               tmr_q <= '0;
            end else begin
               tmr_q <= tmr_q - 1'b1;
            end
         end else if (gnt) begin
            st_q  <= SLOT_ISSUED;
            tmr_q <= TMR_W'(VUL_CYC);
         end else begin
            rdy_q <= rdy_q | hit;
            if ((hit & ~rdy_q) != 2'b00) tmr_q <= TMR_W'(VUL_CYC);
            else if (exposed)            tmr_q <= tmr_q - 1'b1;
         end
      end
   end

   assign req    = (st_q == SLOT_WAIT) && (&rdy_q);
   assign busy   = (st_q != SLOT_FREE);
   assign issued = (st_q == SLOT_ISSUED);
   assign tmr    = tmr_q;

endmodule

// File: rtl/replay_iwin.sv
module replay_iwin
   import replay_iwin_pkg::*;
#(
   parameter  int DEPTH   = DEF_DEPTH,
   parameter  int TAG_W   = DEF_TAG_W,
   parameter  int VUL_CYC = DEF_VUL_CYC,
   localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int TMR_W   = $clog2(VUL_CYC + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             alloc_valid,
   input  logic [TAG_W-1:0] alloc_tag0,
   input  logic [TAG_W-1:0] alloc_tag1,
   input  logic             alloc_rdy0,
   input  logic             alloc_rdy1,
   output logic             alloc_ready,
   input  logic             wb_valid,
   input  logic [TAG_W-1:0] wb_tag,
   input  logic             kill,
   output logic             issue_valid,
   output logic [IDX_W-1:0] issue_idx
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("replay_iwin: DEPTH must be at least 2");
   end
   if (VUL_CYC < 1) begin : g_bad_vul
      $error("replay_iwin: VUL_CYC must be at least 1");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("replay_iwin: TAG_W must be at least 1");
   end

   logic [DEPTH-1:0]            ent_req, ent_busy, ent_iss;
   logic [DEPTH-1:0][TMR_W-1:0] ent_tmr;
   logic [DEPTH-1:0]            iss_oh, free_oh;
   logic [IDX_W-1:0]            free_idx;

   // kill suppresses all grants in its cycle
   replay_iwin_pick #(.W(DEPTH)) u_issue_pick (
      .req    (ent_req & {DEPTH{~kill}}),
      .hit    (issue_valid),
      .idx    (issue_idx),
      .onehot (iss_oh)
   );

   replay_iwin_pick #(.W(DEPTH)) u_free_pick (
      .req    (~ent_busy),
      .hit    (alloc_ready),
      .idx    (free_idx),
      .onehot (free_oh)
   );

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      replay_iwin_slot #(.TAG_W(TAG_W), .VUL_CYC(VUL_CYC)) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .ld       (alloc_valid && free_oh[g]),
         .ld_tag0  (alloc_tag0),
         .ld_tag1  (alloc_tag1),
         .ld_rdy0  (alloc_rdy0),
         .ld_rdy1  (alloc_rdy1),
         .wb_valid (wb_valid),
         .wb_tag   (wb_tag),
         .kill     (kill),
         .gnt      (iss_oh[g]),
         .req      (ent_req[g]),
         .busy     (ent_busy[g]),
         .issued   (ent_iss[g]),
         .tmr      (ent_tmr[g])
      );
   end

   logic unused_free_idx;
   assign unused_free_idx = ^free_idx;

endmodule

// File: rtl/replay_iwin_chk.sv
module replay_iwin_chk #(
   parameter int DEPTH   = 8,
   parameter int VUL_CYC = 4,
   parameter int IDX_W   = 3,
   parameter int TMR_W   = 3
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        kill,
   input logic                        issue_valid,
   input logic [IDX_W-1:0]            issue_idx,
   input logic [DEPTH-1:0]            ent_req,
   input logic [DEPTH-1:0]            ent_busy,
   input logic [DEPTH-1:0]            ent_iss,
   input logic [DEPTH-1:0][TMR_W-1:0] ent_tmr
);

   logic [DEPTH-1:0] below;
   assign below = (DEPTH'(1) << issue_idx) - DEPTH'(1);

   p_lowest_r4: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |-> (ent_req[issue_idx] && ((ent_req & below) == '0)));

   p_quiet_kill_r7: assert property (@(posedge clk) disable iff (!rst_n)
      kill |-> !issue_valid);

   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      p_timer_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
         ent_tmr[g] <= TMR_W'(VUL_CYC));

      p_timer_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (ent_iss[g] && ent_tmr[g] > TMR_W'(1) && !kill)
         |=> (ent_tmr[g] == $past(ent_tmr[g]) - 1'b1));

      p_grant_mark_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (issue_valid && issue_idx == IDX_W'(g))
         |=> (ent_iss[g] && ent_tmr[g] == TMR_W'(VUL_CYC)));

      p_retire_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (ent_iss[g] && ent_tmr[g] == TMR_W'(1) && !kill) |=> !ent_busy[g]);

      p_kill_revert_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (kill && ent_busy[g] && ent_tmr[g] != '0)
         |=> (ent_busy[g] && !ent_iss[g] && !ent_req[g] && ent_tmr[g] == '0));

      p_kill_spare_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (kill && ent_busy[g] && ent_tmr[g] == '0) |=> ent_busy[g]);
   end

endmodule

bind replay_iwin replay_iwin_chk #(
   .DEPTH(DEPTH), .VUL_CYC(VUL_CYC), .IDX_W(IDX_W), .TMR_W(TMR_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .kill        (kill),
   .issue_valid (issue_valid),
   .issue_idx   (issue_idx),
   .ent_req     (ent_req),
   .ent_busy    (ent_busy),
   .ent_iss     (ent_iss),
   .ent_tmr     (ent_tmr)
);

// File: tb/replay_iwin_bench.sv
module replay_iwin_bench;

   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 8;
   localparam int TAG_W      = 5;
   localparam int VUL        = 4;
   localparam int IDX_W      = 3;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             av = 1'b0, ar0 = 1'b0, ar1 = 1'b0, wv = 1'b0, kl = 1'b0;
   logic [TAG_W-1:0] at0 = '0, at1 = '0, wt = '0;
   logic             ardy, iv;
   logic [IDX_W-1:0] ix;

   int nvec = 0;
   int nbad = 0;
   bit done = 1'b0;
   int c_iv, c_ix, c_ar;

   replay_iwin #(.DEPTH(DEPTH), .TAG_W(TAG_W), .VUL_CYC(VUL)) u_replay_iwin (
      .clk(clk), .rst_n(rst_n),
      .alloc_valid(av), .alloc_tag0(at0), .alloc_tag1(at1),
      .alloc_rdy0(ar0), .alloc_rdy1(ar1), .alloc_ready(ardy),
      .wb_valid(wv), .wb_tag(wt), .kill(kl),
      .issue_valid(iv), .issue_idx(ix)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic chk(string req, int act, int exp);
      nvec++;
      if (act != exp) begin
         nbad++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   // apply inputs just after a falling edge, sample outputs, move to next falling edge
   task automatic drive(int a, int t0, int t1, int r0, int r1, int w, int wtag, int k);
      av = a[0]; at0 = TAG_W'(t0); at1 = TAG_W'(t1); ar0 = r0[0]; ar1 = r1[0];
      wv = w[0]; wt = TAG_W'(wtag); kl = k[0];
      #1;
      c_iv = int'(iv); c_ix = int'(ix); c_ar = int'(ardy);
      @(negedge clk);
   endtask

   task automatic idle();
      drive(0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic bcast(int tag);
      drive(0, 0, 0, 0, 0, 1, tag, 0);
   endtask

   task automatic do_kill();
      drive(0, 0, 0, 0, 0, 0, 0, 1);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) idle();
      rst_n = 1'b1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      nbad++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      finish_run();
   end

   initial begin
      @(negedge clk);
      do_reset();

      // R1: empty after reset
      idle();
      chk("R1 alloc_ready", c_ar, 1);
      chk("R1 issue_valid", c_iv, 0);

      // fill all slots; even slots share second tag 20
      for (int i = 0; i < DEPTH; i++) begin
         drive(1, i, (i % 2 == 0) ? 20 : 10 + i, 0, 0, 0, 0, 0);
         chk("R2 alloc_ready while filling", c_ar, 1);
      end
      idle();
      chk("R2 full flag", c_ar, 0);
      drive(1, 30, 30, 1, 1, 0, 0, 0);       // rejected insert
      idle();
      chk("R2 rejected insert issues nothing", c_iv, 0);
      chk("R2 still full", c_ar, 0);

      // R3: half-ready slots stay put
      for (int i = 0; i < DEPTH; i++) begin
         bcast(i);
         chk("R3 one operand only", c_iv, 0);
      end
      bcast(20);
      chk("R3 shared tag cycle", c_iv, 0);
      // R4: four slots wake together, lowest first
      for (int k = 0; k < 4; k++) begin
         idle();
         chk("R4 issue_valid", c_iv, 1);
         chk("R4 lowest index", c_ix, 2 * k);
      end
      idle();
      chk("R4 no further ready", c_iv, 0);
      chk("R6 slot 0 not yet free", c_ar, 0);
      drive(1, 31, 31, 1, 1, 0, 0, 0);
      chk("R6 slot freed after VUL edges", c_ar, 1);
      idle();
      chk("R6 reused slot issues", c_iv, 1);
      chk("R2 reuse takes lowest free slot", c_ix, 0);

      // R7/R6: kill swept over delays after a grant
      for (int d = 0; d <= VUL + 1; d++) begin
         do_reset();
         drive(1, 3, 4, 1, 1, 0, 0, 0);
         idle();
         chk("R4 single grant", c_iv, 1);
         chk("R4 single grant slot", c_ix, 0);
         repeat (d) idle();
         do_kill();
         chk("R7 no issue under kill", c_iv, 0);
         drive(1, 9, 9, 1, 1, 0, 0, 0);
         chk("R7 reverted slot waits", c_iv, 0);
         idle();
         chk("R7 probe issues", c_iv, 1);
         chk("R7 slot kept if inside window", c_ix, (d < VUL) ? 1 : 0);
         if (d < VUL) begin
            bcast(3);
            chk("R8 one tag back", c_iv, 0);
            bcast(4);
            chk("R8 second tag cycle", c_iv, 0);
            idle();
            chk("R8 reissue", c_iv, 1);
            chk("R8 reissue slot", c_ix, 0);
         end
      end

      // R7: slot with zero timer keeps its flags through a kill
      do_reset();
      drive(1, 5, 6, 0, 1, 0, 0, 0);
      drive(1, 7, 8, 1, 1, 0, 0, 0);
      idle();
      chk("R4 ready slot 1 granted", c_ix, 1);
      do_kill();
      bcast(5);
      chk("R7 spare slot not yet ready", c_iv, 0);
      idle();
      chk("R7 spare slot kept flag", c_iv, 1);
      chk("R7 spare slot index", c_ix, 0);
      idle();
      chk("R7 killed slot waits", c_iv, 0);
      bcast(7);
      bcast(8);
      idle();
      chk("R8 killed slot reissues", c_iv, 1);
      chk("R8 killed slot index", c_ix, 1);

      // R3/R5: broadcast gating and wakeup-loaded timer
      do_reset();
      drive(1, 11, 12, 1, 0, 1, 12, 0);      // same-cycle broadcast ignored
      idle();
      chk("R3 same-cycle broadcast ignored", c_iv, 0);
      drive(0, 0, 0, 0, 0, 0, 12, 0);        // gated broadcast
      idle();
      chk("R3 wb_valid low ignored", c_iv, 0);
      bcast(12);
      do_kill();
      chk("R7 kill blocks ready slot", c_iv, 0);
      idle();
      chk("R5 woken slot was exposed", c_iv, 0);
      bcast(11);
      idle();
      chk("R5 both flags were cleared", c_iv, 0);
      bcast(12);
      idle();
      chk("R8 rewoken slot issues", c_iv, 1);
      chk("R8 rewoken slot index", c_ix, 0);

      // R5: timer saturates at zero; old wakeups survive a kill
      do_reset();
      for (int i = 0; i < DEPTH; i++) drive(1, 25, 25, 0, 0, 0, 0, 0);
      bcast(25);
      for (int k = 0; k < 5; k++) begin
         idle();
         chk("R4 staggered grant", c_ix, k);
      end
      do_kill();
      chk("R7 kill cycle", c_iv, 0);
      for (int k = 5; k < DEPTH; k++) begin
         idle();
         chk("R5 saturated slot survives kill", c_iv, 1);
         chk("R5 saturated slot order", c_ix, k);
      end
      idle();
      chk("R7 recent grants reverted", c_iv, 0);
      chk("R6 early grant retired", c_ar, 1);

      finish_run();
   end

endmodule